// File: doc/BRIEF.md
# Dual Audio Sample Queue with Fill-Level Requests

This block sits between a processor or DMA side and an audio serializer. It holds two independent sample queues of 32 words each. The transmit queue is filled by software writes and drained by the serializer. The receive queue is filled by the serializer and drained by software reads. Each queue reports its fill level. Each queue also raises a request flag when its fill level crosses a programmable threshold, so the data mover knows when to act.

Access errors on either side of either queue are recorded in four sticky error flags: a write into a full queue, a push into a full queue, a pop from an empty queue and a read from an empty queue. Each flag stays set until software clears it. Every request and error flag passes through an enable before it reaches an interrupt output. Each queue has its own hold-in-reset input, which empties it and keeps it empty for as long as the input is held.

Top module: `audio_sample_fifo_pair`

## Requirements
- R1: Each queue returns words in the order they were accepted. A transmit pop presents the oldest word on `ser_tx_data` in the cycle after the pop. A receive read presents the oldest word on `rx_rd_data` in the cycle after the read.
- R2: `tx_count` and `rx_count` show the number of stored words, from 0 to 32. Each count changes in the cycle after an accepted access.
- R3: A software write into a full transmit queue is dropped, and `err_flags[1]` is set. A serializer push into a full receive queue is dropped, and `err_flags[3]` is set. Stored contents and counts are not changed.
- R4: A serializer pop from an empty transmit queue drives `ser_tx_data` to zero and sets `err_flags[0]`. A software read from an empty receive queue drives `rx_rd_data` to zero and sets `err_flags[2]`.
- R5: `tx_req` is 1 exactly when `tx_count` is less than or equal to `tx_thr`. It is recomputed from the current count in every cycle.
- R6: `rx_req` is 1 exactly when `rx_count` is greater than `rx_thr`. A threshold of 0 therefore requests on any stored word.
- R7: An error flag stays at 1 until the matching `err_clr` bit is pulsed. If a new error event and a clear strobe arrive in the same cycle, the event wins.
- R8: While `tx_hold_rst` or `rx_hold_rst` is 1, the matching queue reads as empty and its old contents are discarded. Accesses to that queue are ignored and raise no error.
- R9: `irq_err` is the OR of `err_flags & err_ien`. `irq_tx` is `tx_req & tx_req_ien`. `irq_rx` is `rx_req & rx_req_ien`.
- R10: After reset, both counts, all error flags and both data outputs are 0.
- R11: A push and a pop on the same queue in the same cycle, when that queue is neither empty nor full, both succeed and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Software write strobe into the transmit queue |
| tx_wr_data | input | DATA_W | Word to write into the transmit queue |
| ser_tx_pop | input | 1 | Serializer pop strobe on the transmit queue |
| ser_tx_data | output | DATA_W | Word popped by the serializer |
| ser_rx_push | input | 1 | Serializer push strobe into the receive queue |
| ser_rx_data | input | DATA_W | Word pushed by the serializer |
| rx_rd_en | input | 1 | Software read strobe on the receive queue |
| rx_rd_data | output | DATA_W | Word returned by a software read |
| tx_hold_rst | input | 1 | Holds the transmit queue empty |
| rx_hold_rst | input | 1 | Holds the receive queue empty |
| tx_thr | input | $clog2(DEPTH) | Transmit request threshold |
| rx_thr | input | $clog2(DEPTH) | Receive request threshold |
| tx_count | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_count | output | $clog2(DEPTH)+1 | Receive fill level |
| tx_req | output | 1 | Transmit request flag |
| rx_req | output | 1 | Receive request flag |
| err_clr | input | 4 | Clear strobes, one per error flag |
| err_flags | output | 4 | Sticky flags: bit 0 transmit underflow, bit 1 transmit overflow, bit 2 receive underflow, bit 3 receive overflow |
| err_ien | input | 4 | Interrupt enables for the error flags |
| tx_req_ien | input | 1 | Interrupt enable for the transmit request |
| rx_req_ien | input | 1 | Interrupt enable for the receive request |
| irq_err | output | 1 | Error interrupt |
| irq_tx | output | 1 | Transmit request interrupt |
| irq_rx | output | 1 | Receive request interrupt |

## Verification
A read or write pointer that slips shows up at the data outputs one cycle after the next pop or read, as a word out of order or a repeated word. The bench therefore checks every word of a full 32-word drain. A wrong fill counter shows up at once on the count outputs and on the request flags. It also shows up later, when an error flag is raised or missed at the full or empty boundary. A flag register that loses its state shows up as an error bit that drops without a clear strobe, which the bench checks over several idle cycles.

// File: rtl/asf_pkg.sv
package asf_pkg;
   localparam int NUM_ERR = 4;
   localparam int ERR_TX_UNF = 0;
   localparam int ERR_TX_OVF = 1;
   localparam int ERR_RX_UNF = 2;
   localparam int ERR_RX_OVF = 3;

   typedef struct packed {
      logic ovf;
      logic unf;
   } asf_evt_t;
endpackage

// File: rtl/asf_sticky.sv
module asf_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
endmodule

// File: rtl/asf_fifo.sv
module asf_fifo
   import asf_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int DEPTH         = 32,
   parameter bit ZERO_ON_EMPTY = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CW-1:0]     count,
   output asf_evt_t          evt
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("asf_fifo: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("asf_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp_q, rp_q;
   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] dout_q, empty_val;
   logic              full, empty, push_ok, pop_ok;

   assign full    = (cnt_q == FULL_CNT);
   assign empty   = (cnt_q == '0);
   assign push_ok = push && !hold && !full;
   assign pop_ok  = pop  && !hold && !empty;
   assign evt.ovf = push && !hold && full;
   assign evt.unf = pop  && !hold && empty;

   if (ZERO_ON_EMPTY) begin : g_zero_fill
      assign empty_val = '0;
   end else begin : g_repeat_last
      assign empty_val = dout_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (hold) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (pop_ok)  dout_q <= mem[rp_q];
      else if (evt.unf) dout_q <= empty_val;
   end

   assign pop_data = dout_q;
   assign count    = cnt_q;

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   p_hold_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0));
   p_single_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                 || (count + 1'b1 == $past(count))));
   p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !hold && count == FULL_CNT) |=> (count == FULL_CNT));
endmodule

// File: rtl/audio_sample_fifo_pair.sv
module audio_sample_fifo_pair
   import asf_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int DEPTH         = 32,
   parameter bit ZERO_ON_EMPTY = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_wr_en,
   input  logic [DATA_W-1:0]  tx_wr_data,
   input  logic               ser_tx_pop,
   output logic [DATA_W-1:0]  ser_tx_data,
   input  logic               ser_rx_push,
   input  logic [DATA_W-1:0]  ser_rx_data,
   input  logic               rx_rd_en,
   output logic [DATA_W-1:0]  rx_rd_data,
   input  logic               tx_hold_rst,
   input  logic               rx_hold_rst,
   input  logic [AW-1:0]      tx_thr,
   input  logic [AW-1:0]      rx_thr,
   output logic [CW-1:0]      tx_count,
   output logic [CW-1:0]      rx_count,
   output logic               tx_req,
   output logic               rx_req,
   input  logic [NUM_ERR-1:0] err_clr,
   output logic [NUM_ERR-1:0] err_flags,
   input  logic [NUM_ERR-1:0] err_ien,
   input  logic               tx_req_ien,
   input  logic               rx_req_ien,
   output logic               irq_err,
   output logic               irq_tx,
   output logic               irq_rx
);
   asf_evt_t           tx_evt, rx_evt;
   logic [NUM_ERR-1:0] err_set;

   asf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ZERO_ON_EMPTY(ZERO_ON_EMPTY)) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (tx_hold_rst),
      .push      (tx_wr_en),
      .push_data (tx_wr_data),
      .pop       (ser_tx_pop),
      .pop_data  (ser_tx_data),
      .count     (tx_count),
      .evt       (tx_evt)
   );

   asf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ZERO_ON_EMPTY(ZERO_ON_EMPTY)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (rx_hold_rst),
      .push      (ser_rx_push),
      .push_data (ser_rx_data),
      .pop       (rx_rd_en),
      .pop_data  (rx_rd_data),
      .count     (rx_count),
      .evt       (rx_evt)
   );

   always_comb begin
      err_set             = '0;
      err_set[ERR_TX_UNF] = tx_evt.unf;
      err_set[ERR_TX_OVF] = tx_evt.ovf;
      err_set[ERR_RX_UNF] = rx_evt.unf;
      err_set[ERR_RX_OVF] = rx_evt.ovf;
   end

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
      asf_sticky u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (err_set[i]),
         .clr   (err_clr[i]),
         .q     (err_flags[i])
      );
   end

   // Requests follow the live fill levels in every cycle.
   assign tx_req  = (tx_count <= {1'b0, tx_thr});
   assign rx_req  = (rx_count >  {1'b0, rx_thr});
   assign irq_err = |(err_flags & err_ien);
   assign irq_tx  = tx_req & tx_req_ien;
   assign irq_rx  = rx_req & rx_req_ien;

   p_tx_unf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_tx_pop && !tx_hold_rst && tx_count == '0) |=> err_flags[ERR_TX_UNF]);
   p_rx_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_rx_push && !rx_hold_rst && rx_count == CW'(DEPTH)) |=> err_flags[ERR_RX_OVF]);
   p_held_tx_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hold_rst |=> tx_req);
   p_held_rx_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hold_rst |=> !rx_req);
   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (err_flags != '0));
endmodule

// File: tb/audio_sample_fifo_pair_tb.sv
module audio_sample_fifo_pair_tb;
   localparam int DW = 16;
   localparam int DEPTH = 32;
   localparam int VEC_N = 6;
   localparam int V_FILL  [VEC_N] = '{0, 1, 15, 16, 32, 5};
   localparam int V_THR   [VEC_N] = '{0, 0, 15, 15, 31, 31};
   localparam int V_TXREQ [VEC_N] = '{1, 0, 1, 0, 0, 1};
   localparam int V_RXREQ [VEC_N] = '{0, 1, 0, 1, 1, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_wr_en = 0, ser_tx_pop = 0, ser_rx_push = 0, rx_rd_en = 0;
   logic [DW-1:0] tx_wr_data = '0, ser_rx_data = '0;
   logic [DW-1:0] ser_tx_data, rx_rd_data;
   logic tx_hold_rst = 0, rx_hold_rst = 0;
   logic [4:0] tx_thr = '0, rx_thr = '0;
   logic [5:0] tx_count, rx_count;
   logic tx_req, rx_req;
   logic [3:0] err_clr = '0, err_flags, err_ien = '0;
   logic tx_req_ien = 0, rx_req_ien = 0;
   logic irq_err, irq_tx, irq_rx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   audio_sample_fifo_pair u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
      .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
      .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
      .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
      .tx_hold_rst(tx_hold_rst), .rx_hold_rst(rx_hold_rst),
      .tx_thr(tx_thr), .rx_thr(rx_thr),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_req(tx_req), .rx_req(rx_req),
      .err_clr(err_clr), .err_flags(err_flags), .err_ien(err_ien),
      .tx_req_ien(tx_req_ien), .rx_req_ien(rx_req_ien),
      .irq_err(irq_err), .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic hold_both();
      tx_hold_rst = 1; rx_hold_rst = 1; step();
      tx_hold_rst = 0; rx_hold_rst = 0;
   endtask

   task automatic clear_errs();
      err_clr = 4'hF; step(); err_clr = 4'h0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      // R10: reset state
      chk("R10 tx_count", tx_count, 0);
      chk("R10 rx_count", rx_count, 0);
      chk("R10 err_flags", err_flags, 0);
      chk("R10 ser_tx_data", ser_tx_data, 0);
      chk("R10 rx_rd_data", rx_rd_data, 0);

      // R2 R5 R6: vector table of fill levels and thresholds
      for (int i = 0; i < VEC_N; i++) begin
         tx_thr = 5'(V_THR[i]); rx_thr = 5'(V_THR[i]);
         hold_both();
         for (int k = 0; k < V_FILL[i]; k++) begin
            tx_wr_en = 1; tx_wr_data = DW'(k);
            ser_rx_push = 1; ser_rx_data = DW'(k);
            step();
         end
         tx_wr_en = 0; ser_rx_push = 0;
         chk($sformatf("R2 tx_count vec%0d", i), tx_count, V_FILL[i]);
         chk($sformatf("R2 rx_count vec%0d", i), rx_count, V_FILL[i]);
         chk($sformatf("R5 tx_req vec%0d", i), tx_req, V_TXREQ[i]);
         chk($sformatf("R6 rx_req vec%0d", i), rx_req, V_RXREQ[i]);
      end
      chk("R3 no overflow at exactly full", err_flags, 0);

      // R1: ordering on transmit
      hold_both();
      tx_wr_en = 1; tx_wr_data = 16'hA1; step();
      tx_wr_data = 16'hB2; step();
      tx_wr_data = 16'hC3; step();
      tx_wr_en = 0;
      ser_tx_pop = 1; step(); chk("R1 first word", ser_tx_data, 16'hA1);
      step(); chk("R1 second word", ser_tx_data, 16'hB2);
      step(); chk("R1 third word", ser_tx_data, 16'hC3);
      ser_tx_pop = 0;
      chk("R2 tx drained", tx_count, 0);

      // R4: underflow on both queues
      ser_tx_pop = 1; step(); ser_tx_pop = 0;
      chk("R4 tx empty pop data", ser_tx_data, 0);
      chk("R4 tx underflow flag", err_flags, 4'b0001);
      rx_rd_en = 1; step(); rx_rd_en = 0;
      chk("R4 rx empty read data", rx_rd_data, 0);
      chk("R4 rx underflow flag", err_flags, 4'b0101);

      // R7: sticky, clear, set beats clear
      repeat (3) step();
      chk("R7 flags persist", err_flags, 4'b0101);
      err_clr = 4'b0001; step(); err_clr = 0;
      chk("R7 clear one flag", err_flags, 4'b0100);
      ser_tx_pop = 1; err_clr = 4'b0001; step(); ser_tx_pop = 0; err_clr = 0;
      chk("R7 set wins over clear", err_flags, 4'b0101);

      // R9: interrupt gating
      err_ien = 4'b0000; step();
      chk("R9 irq_err all disabled", irq_err, 0);
      err_ien = 4'b0100; step();
      chk("R9 irq_err enabled set flag", irq_err, 1);
      err_ien = 4'b1010; step();
      chk("R9 irq_err enabled clear flags", irq_err, 0);
      err_ien = 0;
      tx_thr = 5'd3; rx_thr = 5'd0;
      tx_req_ien = 1; rx_req_ien = 1; step();
      chk("R9 irq_tx enabled", irq_tx, 1);
      chk("R9 irq_rx no data", irq_rx, 0);
      tx_req_ien = 0; step();
      chk("R9 irq_tx disabled", irq_tx, 0);
      rx_req_ien = 0;
      clear_errs();
      chk("R7 clear all", err_flags, 0);

      // R3: transmit overflow, contents intact
      hold_both();
      for (int k = 0; k < DEPTH; k++) begin
         tx_wr_en = 1; tx_wr_data = DW'(100 + k); step();
      end
      tx_wr_data = 16'd999; step(); tx_wr_en = 0;
      chk("R3 tx count stays full", tx_count, DEPTH);
      chk("R3 tx overflow flag", err_flags, 4'b0010);
      ser_tx_pop = 1;
      for (int k = 0; k < DEPTH; k++) begin
         step();
         chk($sformatf("R3 tx drain word %0d", k), ser_tx_data, 100 + k);
      end
      ser_tx_pop = 0;
      chk("R3 tx empty after drain", tx_count, 0);

      // R3: receive overflow
      for (int k = 0; k < DEPTH; k++) begin
         ser_rx_push = 1; ser_rx_data = DW'(200 + k); step();
      end
      ser_rx_data = 16'd777; step(); ser_rx_push = 0;
      chk("R3 rx count stays full", rx_count, DEPTH);
      chk("R3 rx overflow flag", err_flags, 4'b1010);
      rx_rd_en = 1;
      for (int k = 0; k < DEPTH; k++) begin
         step();
         chk($sformatf("R3 rx drain word %0d", k), rx_rd_data, 200 + k);
      end
      rx_rd_en = 0;
      clear_errs();

      // R11: simultaneous push and read on receive
      ser_rx_push = 1; ser_rx_data = 16'd1; step();
      ser_rx_data = 16'd2; step();
      ser_rx_data = 16'd3; rx_rd_en = 1; step();
      ser_rx_push = 0;
      chk("R11 count unchanged", rx_count, 2);
      chk("R11 read during push", rx_rd_data, 1);
      step(); chk("R11 next word", rx_rd_data, 2);
      step(); chk("R11 pushed word kept", rx_rd_data, 3);
      rx_rd_en = 0;
      chk("R11 no errors", err_flags, 0);

      // R8: hold-in-reset discards and ignores
      for (int k = 0; k < 4; k++) begin
         tx_wr_en = 1; tx_wr_data = DW'(50 + k); step();
      end
      tx_wr_en = 0;
      tx_hold_rst = 1; step();
      chk("R8 held queue empty", tx_count, 0);
      tx_wr_en = 1; ser_tx_pop = 1; step();
      tx_wr_en = 0; ser_tx_pop = 0;
      chk("R8 write ignored while held", tx_count, 0);
      chk("R8 no error while held", err_flags, 0);
      tx_hold_rst = 0; step();
      ser_tx_pop = 1; step(); ser_tx_pop = 0;
      chk("R8 old contents discarded", ser_tx_data, 0);
      chk("R8 pop after release underflows", err_flags, 4'b0001);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule